// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps a bank of asynchronous DRAM alive. After reset it holds the memory idle for the power-up pause. It then runs a fixed number of warm-up refresh cycles and raises a ready flag for the host. From then on, an interval timer schedules one refresh about every 15.6 us, which covers 2048 rows in 32 ms.

Every refresh is a column-strobe-before-row-strobe cycle. The memory's internal row counter picks the row, so the block drives no address and no data. Write-enable stays high for the whole cycle.

The block shares the strobes with an access controller. It asks for the bus with a request line and starts a cycle only when the grant is present. While it drives the strobes, an ownership-select output tells the board multiplexer to take the block's strobe values. When the access controller keeps the grant back, the owed refreshes pile up in a saturating backlog. They are issued back to back once the grant arrives.

All timings are derived from a clock-frequency parameter and nanosecond or microsecond parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: For the first POWERUP_US x CLK_MHZ cycles after reset (20000 at the defaults), busReq and initDone stay low, drvEn stays low and every strobe output stays high.
- R2: After the power-up wait, exactly WARMUP (8) refresh cycles run before initDone rises. initDone then stays high until reset.
- R3: In every refresh cycle, all casN bits go low at least one clock before rasN falls. They are low in exactly the first CHR cycle (1 at the defaults) of rasN low, and high again before rasN rises.
- R4: rasN stays low for exactly RAS cycles (5 at 100 MHz, covering 50 ns). It is then high for at least RP cycles (3, covering 30 ns) before it falls again.
- R5: weN is high in every cycle in which drvEn is high.
- R6: Once initDone is high and the grant is given at once, successive rasN falls are exactly floor(RETENTION_MS x 1000 x CLK_MHZ / ROWS) cycles apart (1562). A 40000-cycle window therefore holds 25 or 26 refreshes, which meets the rate of 2048 rows per 32 ms.
- R7: Refresh intervals that elapse without a grant are owed, up to MAX_POSTPONE (8). When the grant comes after k owed intervals, exactly min(k, 8) cycles are issued.
- R8: busReq stays high while at least one refresh is owed and drops in the cycle after the last owed refresh completes.
- R9: A refresh cycle starts only while busGnt is high. Whenever busGnt is low, drvEn is low and rasN and casN are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGnt | input | 1 | Grant from the access controller, held while busReq is high |
| busReq | output | 1 | Refresh bus request |
| drvEn | output | 1 | Ownership select: high while this block drives the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | NUM_CAS | Column strobes, active low, all driven together |
| weN | output | 1 | Write-enable, active low (held high) |
| initDone | output | 1 | Memory ready for normal use |

## Verification
The refresh cycle is driven under three grant patterns. An immediate grant gives back-to-back scheduled refreshes with an exact, fixed spacing, which separates a correct interval from an off-by-one timer and supports the rate check. A grant withheld for one to twelve intervals and then given after a varied latency shows whether the backlog counts each missed tick, saturates at eight, and holds the request until the last one. The power-up phase, granted from the start, tells apart a correct wait and warm-up count from an early start or a short or long warm-up. The strobe waveform is checked edge by edge in every cycle of every pattern.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CAS_LEAD,
    S_RAS_HOLD,
    S_RAS_TAIL,
    S_PRECH
  } seqState_t;

  // phaseSel: 0 column lead, 1 column hold, 2 row tail, 3 precharge
  typedef struct packed {
    logic       phaseLoad;
    logic [1:0] phaseSel;
    logic       cycleDone;
  } seqCtl_t;

  function automatic int nsToCyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/refseq_datapath.sv
module refseq_datapath
  import refseq_pkg::*;
#(
  parameter int PWR_CYC      = 20000,
  parameter int REFI_CYC     = 1562,
  parameter int WARMUP       = 8,
  parameter int MAX_POSTPONE = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int TAIL_CYC     = 4,
  parameter int RP_CYC       = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  seqCtl_t ctl,
  output logic    phaseZero,
  output logic    busReq,
  output logic    initDone
);

  localparam int MAXPH = (CSR_CYC > CHR_CYC ? CSR_CYC : CHR_CYC) > (TAIL_CYC > RP_CYC ? TAIL_CYC : RP_CYC)
                       ? (CSR_CYC > CHR_CYC ? CSR_CYC : CHR_CYC) : (TAIL_CYC > RP_CYC ? TAIL_CYC : RP_CYC);
  localparam int PH_W  = $clog2(MAXPH + 1);
  localparam int PW_W  = $clog2(PWR_CYC + 1);
  localparam int RI_W  = $clog2(REFI_CYC + 1);
  localparam int BL_W  = $clog2(MAX_POSTPONE + 1);
  localparam int WU_W  = $clog2(WARMUP + 1);

  logic [PH_W-1:0] phaseCnt, phaseVal;
  logic [PW_W-1:0] pwrCnt;
  logic [RI_W-1:0] refiCnt;
  logic [BL_W-1:0] backlog;
  logic [WU_W-1:0] warmLeft;
  logic            waitDone, tick, decBacklog;

  // phase counter shared by every step of the cycle
  always_comb begin
    unique case (ctl.phaseSel)
      2'd0:    phaseVal = PH_W'(CSR_CYC - 1);
      2'd1:    phaseVal = PH_W'(CHR_CYC - 1);
      2'd2:    phaseVal = PH_W'(TAIL_CYC - 1);
      default: phaseVal = PH_W'(RP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               phaseCnt <= '0;
    else if (ctl.phaseLoad)  phaseCnt <= phaseVal;
    else if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
  end
  assign phaseZero = (phaseCnt == '0);

  // power-up pause
  always_ff @(posedge clk) begin
    if (!rstN)                        pwrCnt <= '0;
    else if (pwrCnt != PW_W'(PWR_CYC)) pwrCnt <= pwrCnt + 1'b1;
  end
  assign waitDone = (pwrCnt == PW_W'(PWR_CYC));

  // warm-up count
  always_ff @(posedge clk) begin
    if (!rstN)                                  warmLeft <= WU_W'(WARMUP);
    else if (ctl.cycleDone && warmLeft != '0)   warmLeft <= warmLeft - 1'b1;
  end
  assign initDone = waitDone && (warmLeft == '0);

  // interval timer, running once ready
  always_ff @(posedge clk) begin
    if (!rstN || !initDone)                    refiCnt <= '0;
    else if (refiCnt == RI_W'(REFI_CYC - 1))   refiCnt <= '0;
    else                                       refiCnt <= refiCnt + 1'b1;
  end
  assign tick = initDone && (refiCnt == RI_W'(REFI_CYC - 1));

  // saturating backlog of owed refreshes
  assign decBacklog = ctl.cycleDone && initDone;
  always_ff @(posedge clk) begin
    if (!rstN) backlog <= '0;
    else if (tick && !decBacklog) begin
      if (backlog != BL_W'(MAX_POSTPONE)) backlog <= backlog + 1'b1;
    end else if (decBacklog && !tick && backlog != '0) begin
      backlog <= backlog - 1'b1;
    end
  end

  assign busReq = (backlog != '0) || (waitDone && warmLeft != '0);

  // R7
  backlog_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    backlog <= BL_W'(MAX_POSTPONE));
  // R2
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);
  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(ctl.cycleDone));

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
#(
  parameter int NUM_CAS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReq,
  input  logic               busGnt,
  input  logic               phaseZero,
  output seqCtl_t            ctl,
  output logic               drvEn,
  output logic               rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN
);

  seqState_t state, nextState;

  always_comb begin
    nextState     = state;
    ctl           = '0;
    unique case (state)
      S_IDLE: if (busReq && busGnt) begin
        nextState    = S_CAS_LEAD;
        ctl.phaseLoad = 1'b1;
        ctl.phaseSel  = 2'd0;
      end
      S_CAS_LEAD: if (phaseZero) begin
        nextState    = S_RAS_HOLD;
        ctl.phaseLoad = 1'b1;
        ctl.phaseSel  = 2'd1;
      end
      S_RAS_HOLD: if (phaseZero) begin
        nextState    = S_RAS_TAIL;
        ctl.phaseLoad = 1'b1;
        ctl.phaseSel  = 2'd2;
      end
      S_RAS_TAIL: if (phaseZero) begin
        nextState    = S_PRECH;
        ctl.phaseLoad = 1'b1;
        ctl.phaseSel  = 2'd3;
      end
      S_PRECH: if (phaseZero) begin
        nextState     = S_IDLE;
        ctl.cycleDone = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign drvEn = (state != S_IDLE);
  assign rasN  = !(state == S_RAS_HOLD || state == S_RAS_TAIL);
  assign casN  = (state == S_CAS_LEAD || state == S_RAS_HOLD) ? '0 : '1;
  assign weN   = 1'b1;

  // R3
  ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (casN == '0) && ($past(casN) == '0));
  // R3
  start_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEn) |-> rasN && (casN == '0));
  // R9
  owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEn) |-> $past(busGnt) && $past(busReq));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import refseq_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int POWERUP_US   = 200,
  parameter int ROWS         = 2048,
  parameter int RETENTION_MS = 32,
  parameter int WARMUP       = 8,
  parameter int MAX_POSTPONE = 8,
  parameter int NUM_CAS      = 4,
  parameter int T_CSR_NS     = 5,
  parameter int T_CHR_NS     = 10,
  parameter int T_WSU_NS     = 10,
  parameter int T_WHD_NS     = 10,
  parameter int T_RAS_NS     = 50,
  parameter int T_RP_NS      = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busGnt,
  output logic               busReq,
  output logic               drvEn,
  output logic               rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN,
  output logic               initDone
);

  localparam int CSR_A    = nsToCyc(T_CSR_NS, CLK_MHZ);
  localparam int CSR_B    = nsToCyc(T_WSU_NS, CLK_MHZ);
  localparam int CHR_A    = nsToCyc(T_CHR_NS, CLK_MHZ);
  localparam int CHR_B    = nsToCyc(T_WHD_NS, CLK_MHZ);
  localparam int CSR_CYC  = CSR_A > CSR_B ? CSR_A : CSR_B;
  localparam int CHR_CYC  = CHR_A > CHR_B ? CHR_A : CHR_B;
  localparam int RAS_CYC  = nsToCyc(T_RAS_NS, CLK_MHZ);
  localparam int RP_CYC   = nsToCyc(T_RP_NS, CLK_MHZ);
  localparam int TAIL_CYC = RAS_CYC > CHR_CYC ? RAS_CYC - CHR_CYC : 1;
  localparam int PWR_CYC  = POWERUP_US * CLK_MHZ;
  localparam int REFI_CYC = (RETENTION_MS * 1000 * CLK_MHZ) / ROWS;

  seqCtl_t ctl;
  logic    phaseZero;

  refseq_datapath #(
    .PWR_CYC(PWR_CYC), .REFI_CYC(REFI_CYC), .WARMUP(WARMUP),
    .MAX_POSTPONE(MAX_POSTPONE), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
    .TAIL_CYC(TAIL_CYC), .RP_CYC(RP_CYC)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phaseZero(phaseZero),
    .busReq(busReq), .initDone(initDone)
  );

  refseq_ctrl #(.NUM_CAS(NUM_CAS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt),
    .phaseZero(phaseZero), .ctl(ctl), .drvEn(drvEn), .rasN(rasN),
    .casN(casN), .weN(weN)
  );

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

  localparam int PWR   = 20000;
  localparam int REFI  = 1562;
  localparam int RASW  = 5;
  localparam int RPW   = 3;
  localparam int CHRW  = 1;
  localparam int NVEC  = 6;
  // owed intervals, grant latency, expected burst
  localparam int VEC [NVEC][3] = '{
    '{1, 0, 1}, '{2, 5, 2}, '{3, 17, 3}, '{8, 2, 8}, '{9, 40, 8}, '{12, 1, 8}
  };

  logic       clk = 0, rstN = 0;
  logic       busGnt, busReq, drvEn, rasN, weN, initDone;
  logic [3:0] casN;
  logic       autoGrant = 1, gntAuto = 0, manualGnt = 0;
  int checks = 0, errors = 0, cycle = 0, rasFalls = 0, firstFall = -1;
  int lastFall = -1, rasLow = 0, casInRas = 0, casLead = 0, highRun = 100;
  bit gapCheck = 0, prevRas = 1, prevInit = 0, done = 0;

  assign busGnt = autoGrant ? gntAuto : manualGnt;

  dram_refresh_seq i_dram_refresh_seq (
    .clk(clk), .rstN(rstN), .busGnt(busGnt), .busReq(busReq), .drvEn(drvEn),
    .rasN(rasN), .casN(casN), .weN(weN), .initDone(initDone)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    gntAuto = busReq;
  end

  // waveform monitor
  always @(negedge clk) if (rstN) begin
    cycle++;
    if (!busGnt) check(!drvEn && rasN && casN == 4'hF, "R9", {drvEn, rasN}, 1);
    if (drvEn) check(weN, "R5", weN, 1);
    if (prevRas && !rasN) begin
      check(casN == 4'h0, "R3", casN, 0);
      check(casLead >= 1, "R3", casLead, 1);
      check(highRun >= RPW, "R4", highRun, RPW);
      rasFalls++;
      if (firstFall < 0) firstFall = cycle;
      if (gapCheck && lastFall >= 0) check(cycle - lastFall == REFI, "R6", cycle - lastFall, REFI);
      lastFall = cycle;
      rasLow   = 1;
      casInRas = (casN == 4'h0) ? 1 : 0;
    end else if (!rasN) begin
      rasLow++;
      if (casN == 4'h0) casInRas++;
    end
    if (!prevRas && rasN) begin
      check(rasLow == RASW, "R4", rasLow, RASW);
      check(casInRas == CHRW, "R3", casInRas, CHRW);
      check(casN == 4'hF, "R3", casN, 15);
      highRun = 1;
    end else if (rasN) highRun++;
    if (rasN && casN == 4'h0) casLead++;
    else if (rasN) casLead = 0;
    if (initDone && !prevInit) begin
      check(rasFalls == 8, "R2", rasFalls, 8);
      check(rasN, "R2", rasN, 1);
    end
    if (prevInit) check(initDone, "R2", initDone, 1);
    prevRas  = rasN;
    prevInit = initDone;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (10) @(negedge clk);
    check(!busReq && !initDone && !drvEn && rasN && casN == 4'hF && weN, "R1", busReq, 0);
    repeat (PWR - 20) @(negedge clk);
    check(!busReq && !initDone && rasN, "R1", busReq, 0);
    wait (initDone);
    @(negedge clk);
    check(firstFall >= PWR, "R1", firstFall, PWR);
    // scheduled rate with immediate grant
    lastFall = -1;
    gapCheck = 1;
    begin
      int startCnt;
      startCnt = rasFalls;
      repeat (40000) @(negedge clk);
      check(rasFalls - startCnt >= 25 && rasFalls - startCnt <= 26, "R6", rasFalls - startCnt, 25);
    end
    gapCheck = 0;
    while (busReq || drvEn) @(negedge clk);
    autoGrant = 0;
    manualGnt = 0;
    // withheld grant patterns
    for (int v = 0; v < NVEC; v++) begin
      int base;
      while (!busReq) @(negedge clk);
      repeat ((VEC[v][0] - 1) * REFI + REFI / 2 + VEC[v][1]) @(negedge clk);
      check(busReq && rasN, "R8", busReq, 1);
      base = rasFalls;
      manualGnt = 1;
      while (busReq) @(negedge clk);
      check(rasFalls - base == VEC[v][2], "R7", rasFalls - base, VEC[v][2]);
      check(!drvEn && rasN, "R8", drvEn, 0);
      manualGnt = 0;
      repeat (2) @(negedge clk);
      check(!busReq, "R8", busReq, 0);
    end
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 180000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check(0, "watchdog", n, 180000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule